// File: doc/BRIEF.md
# Self-Refresh Entry and Exit Sequencer

This block steps a DDR SDRAM into its self-refresh low-power mode and brings it back out safely. On an entry request, when every bank is idle, it drives one refresh-coded command with clock enable low. It then keeps clock enable low while the memory keeps its own contents. On an exit request it waits until the controller reports a stable clock. Only then does it raise clock enable. It next sends a fixed run of NOPs so that any internal refresh can finish. After that it issues a mode-register command that resets the DLL, and then sends a further lockout run of NOPs while the DLL relocks. Only after the lockout does it report that normal commands, reads included, may resume.

The command is a 3-bit code {row strobe, column strobe, write enable}, all active low. NOP is 3'b111, refresh is 3'b001 and mode-register set is 3'b000. A separate output marks the mode-register command as a DLL reset. The states are IDLE, READY, ENTER, IN_SR, WAIT_CLK, XSNR_NOP, DLL_RST and DLL_NOP. The transitions are:
- IDLE→READY after reset.
- READY→ENTER on an accepted entry request.
- ENTER→IN_SR unconditionally.
- IN_SR→WAIT_CLK on an exit request, either live or held from ENTER.
- WAIT_CLK→XSNR_NOP once the clock is stable.
- XSNR_NOP→DLL_RST when the recovery count runs out.
- DLL_RST→DLL_NOP unconditionally.
- DLL_NOP→READY when the lockout count runs out.

Top module: `sr_exit_seq`

## Requirements
- R1: With the block ready, an entry request with `banks_idle` high causes, in the next cycle, exactly one cycle of `cmd` = 3'b001 with `cke` low.
- R2: After that refresh-coded cycle and until the exit path starts, `cke` stays low, `cmd` is NOP (3'b111) and `ready` is low.
- R3: An exit request that is seen only during the refresh-coded cycle is held and starts the exit once the block is in self-refresh, with no further request needed.
- R4: Once an exit is requested, `cke` stays low for every cycle in which `clk_stable` has not yet been seen high, and it rises in the cycle after `clk_stable` is sampled high.
- R5: From the first cycle with `cke` high, exactly `EXIT_NOP_CYC` NOP cycles are issued before the mode-register command.
- R6: The exit path then issues exactly one cycle of `cmd` = 3'b000 with `dll_rst` high and `cke` high. `dll_rst` is low in every other cycle.
- R7: After the DLL-reset cycle, exactly `LOCK_CYC` NOP cycles (default 200) are issued with `ready` low. `ready` rises in the following cycle.
- R8: During and after reset, `ready` is low, `cke` is high and `cmd` is NOP. `ready` goes high one cycle after reset is released and is low for the whole entry and exit sequence.
- R9: An entry request while `banks_idle` is low is ignored: `ready` and `cke` stay high. It also sets `err`, which stays high until reset.
- R10: An exit request while the block is ready is ignored: `ready` and `cke` stay high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enter_req | input | 1 | Request to enter self-refresh |
| exit_req | input | 1 | Request to leave self-refresh |
| banks_idle | input | 1 | All banks precharged and idle |
| clk_stable | input | 1 | Memory clock pair is stable |
| cke | output | 1 | Clock enable to the memory |
| cmd | output | 3 | Command code {ras_n, cas_n, we_n} |
| dll_rst | output | 1 | Mode-register command carries a DLL reset |
| ready | output | 1 | Normal commands, reads included, allowed |
| err | output | 1 | Sticky: entry requested with banks busy |

## Verification
The assertions check several rules on every cycle: the refresh code only ever appears with `cke` low, `cke` never rises before the clock is reported stable, the cycle before the mode-register command is a NOP with `cke` high, `ready` only appears with a NOP and `cke` high, and `err` is sticky. The exact lengths of the recovery and lockout NOP runs can only be shown by the bench's scenarios, which count them. The same holds for the held exit request that arrives during the refresh-coded cycle, and for the requests that must be ignored. The bench sweeps when the exit request arrives and how long the clock takes to become stable.

// File: rtl/sr_exit_seq_pkg.sv
`timescale 1ns/1ps
package sr_exit_seq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_READY    = 3'd1,
        ST_ENTER    = 3'd2,
        ST_IN_SR    = 3'd3,
        ST_WAIT_CLK = 3'd4,
        ST_XSNR_NOP = 3'd5,
        ST_DLL_RST  = 3'd6,
        ST_DLL_NOP  = 3'd7
    } sr_state_e;

    localparam logic [2:0] CMD_NOP = 3'b111;
    localparam logic [2:0] CMD_REF = 3'b001;
    localparam logic [2:0] CMD_MRS = 3'b000;
endpackage

// File: rtl/sr_flag.sv
`timescale 1ns/1ps
module sr_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic q
);
    always_ff @(posedge clk) begin
        if (!rst_n) q <= 1'b0;
        else        q <= set | (q & ~clr);
    end
endmodule

// File: rtl/sr_dwell_cnt.sv
`timescale 1ns/1ps
module sr_dwell_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)           cnt <= '0;
        else if (load)        cnt <= load_val;
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/sr_exit_seq.sv
`timescale 1ns/1ps
module sr_exit_seq
    import sr_exit_seq_pkg::*;
#(
    parameter int EXIT_NOP_CYC = 20,
    parameter int LOCK_CYC     = 200
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enter_req,
    input  logic       exit_req,
    input  logic       banks_idle,
    input  logic       clk_stable,
    output logic       cke,
    output logic [2:0] cmd,
    output logic       dll_rst,
    output logic       ready,
    output logic       err
);
    localparam int MAXC = (EXIT_NOP_CYC > LOCK_CYC) ? EXIT_NOP_CYC : LOCK_CYC;
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] EXIT_LD = CW'(EXIT_NOP_CYC - 1);
    localparam logic [CW-1:0] LOCK_LD = CW'(LOCK_CYC - 1);

    sr_state_e     state, nxt;
    logic          exit_pend;
    logic          cnt_zero;
    logic          cnt_load;
    logic [CW-1:0] cnt_val;
    logic          entry_ok;
    logic          entry_bad;

    assign entry_ok  = (state == ST_READY) && enter_req && banks_idle;
    assign entry_bad = (state == ST_READY) && enter_req && !banks_idle;

    // Exit request seen during the refresh-coded cycle is held
    sr_flag u_pend (
        .clk  (clk),
        .rst_n(rst_n),
        .set  ((state == ST_ENTER) && exit_req),
        .clr  (state == ST_WAIT_CLK),
        .q    (exit_pend)
    );

    sr_flag u_err (
        .clk  (clk),
        .rst_n(rst_n),
        .set  (entry_bad),
        .clr  (1'b0),
        .q    (err)
    );

    always_comb begin
        cnt_load = 1'b0;
        cnt_val  = EXIT_LD;
        if ((state == ST_WAIT_CLK) && clk_stable) begin
            cnt_load = 1'b1;
            cnt_val  = EXIT_LD;
        end else if (state == ST_DLL_RST) begin
            cnt_load = 1'b1;
            cnt_val  = LOCK_LD;
        end
    end

    sr_dwell_cnt #(.W(CW)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (cnt_load),
        .load_val(cnt_val),
        .zero    (cnt_zero)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:     nxt = ST_READY;
            ST_READY:    if (entry_ok) nxt = ST_ENTER;
            ST_ENTER:    nxt = ST_IN_SR;
            ST_IN_SR:    if (exit_req || exit_pend) nxt = ST_WAIT_CLK;
            ST_WAIT_CLK: if (clk_stable) nxt = ST_XSNR_NOP;
            ST_XSNR_NOP: if (cnt_zero) nxt = ST_DLL_RST;
            ST_DLL_RST:  nxt = ST_DLL_NOP;
            ST_DLL_NOP:  if (cnt_zero) nxt = ST_READY;
            default:     nxt = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        cke     = 1'b1;
        cmd     = CMD_NOP;
        dll_rst = 1'b0;
        ready   = 1'b0;
        unique case (state)
            ST_IDLE:     ;
            ST_READY:    ready = 1'b1;
            ST_ENTER:    begin cke = 1'b0; cmd = CMD_REF; end
            ST_IN_SR:    cke = 1'b0;
            ST_WAIT_CLK: cke = 1'b0;
            ST_XSNR_NOP: ;
            ST_DLL_RST:  begin cmd = CMD_MRS; dll_rst = 1'b1; end
            ST_DLL_NOP:  ;
            default:     ;
        endcase
    end
endmodule

// File: rtl/sr_exit_seq_chk.sv
`timescale 1ns/1ps
module sr_exit_seq_chk
    import sr_exit_seq_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       enter_req,
    input logic       exit_req,
    input logic       banks_idle,
    input logic       clk_stable,
    input logic       cke,
    input logic [2:0] cmd,
    input logic       dll_rst,
    input logic       ready,
    input logic       err
);
    p_ref_low_cke_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_REF) |-> !cke);

    p_entry_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && enter_req && banks_idle) |=> (cmd == CMD_REF && !cke));

    p_cke_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke && !clk_stable) |=> !cke);

    p_rise_nop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cke) |-> (cmd == CMD_NOP && !ready));

    p_mrs_after_nop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_MRS) |-> ($past(cke) && $past(cmd) == CMD_NOP && dll_rst));

    p_ready_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (cke && cmd == CMD_NOP));

    p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);

    p_busy_entry_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && enter_req && !banks_idle) |=> (err && ready && cke));

    p_exit_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && exit_req && !enter_req) |=> ready);
endmodule

bind sr_exit_seq sr_exit_seq_chk u_chk (.*);

// File: tb/tb_sr_exit_seq.sv
`timescale 1ns/1ps
module tb_sr_exit_seq;
    import sr_exit_seq_pkg::*;

    localparam int N = 5;
    localparam int L = 200;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enter_req = 1'b0;
    logic       exit_req = 1'b0;
    logic       banks_idle = 1'b1;
    logic       clk_stable = 1'b0;
    logic       cke;
    logic [2:0] cmd;
    logic       dll_rst;
    logic       ready;
    logic       err;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    sr_exit_seq #(.EXIT_NOP_CYC(N), .LOCK_CYC(L)) dut (
        .clk(clk), .rst_n(rst_n), .enter_req(enter_req), .exit_req(exit_req),
        .banks_idle(banks_idle), .clk_stable(clk_stable), .cke(cke), .cmd(cmd),
        .dll_rst(dll_rst), .ready(ready), .err(err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic run_seq(input int early, input int gap, input int stab);
        int n_x = 0;
        int n_d = 0;
        int guard = 0;
        int bad = 0;
        clk_stable = 1'b0;
        @(negedge clk);
        chk(ready == 1'b1, "R8 ready before entry", ready, 1);
        enter_req = 1'b1; banks_idle = 1'b1;
        @(negedge clk);
        enter_req = 1'b0;
        chk(cmd == CMD_REF && !cke, "R1 refresh with cke low", {cke, cmd}, {1'b0, CMD_REF});
        if (early != 0) exit_req = 1'b1;
        @(negedge clk);
        exit_req = 1'b0;
        chk(!cke && cmd == CMD_NOP && !ready, "R2 in self-refresh", {ready, cke, cmd}, {2'b00, CMD_NOP});
        if (early == 0) begin
            for (int i = 0; i < gap; i++) begin
                @(negedge clk);
                chk(!cke && cmd == CMD_NOP, "R2 hold", {cke, cmd}, {1'b0, CMD_NOP});
            end
            exit_req = 1'b1;
            @(negedge clk);
            exit_req = 1'b0;
        end
        for (int i = 0; i < stab; i++) begin
            @(negedge clk);
            chk(!cke, "R4 cke low until clock stable", cke, 0);
        end
        clk_stable = 1'b1;
        while (cmd != CMD_MRS && guard < 1000) begin
            @(negedge clk);
            guard++;
            if (ready) bad++;
            if (cmd == CMD_NOP && cke) n_x++;
        end
        chk(n_x == N, early != 0 ? "R3 R5 held exit, recovery NOPs" : "R5 recovery NOPs", n_x, N);
        chk(dll_rst && cke && cmd == CMD_MRS, "R6 DLL reset command", {dll_rst, cke, cmd}, {2'b11, CMD_MRS});
        while (!ready && guard < 2000) begin
            @(negedge clk);
            guard++;
            if (dll_rst && cmd != CMD_MRS) bad++;
            if (!ready && cmd == CMD_NOP && cke) n_d++;
        end
        chk(n_d == L, "R7 lockout NOPs", n_d, L);
        chk(ready && cke, "R7 ready after lockout", ready, 1);
        chk(bad == 0, "R8 ready low in sequence", bad, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!ready && cke && cmd == CMD_NOP && !err, "R8 reset state",
            {err, ready, cke, cmd}, {3'b001, CMD_NOP});
        rst_n = 1'b1;
        @(negedge clk);
        chk(ready == 1'b1, "R8 ready after reset", ready, 1);

        for (int s = 0; s < 4; s++) run_seq(1, 0, s);
        for (int g = 0; g < 3; g++)
            for (int s = 0; s < 4; s++) run_seq(0, g, s);
        chk(err == 1'b0, "R9 no error on valid entries", err, 0);

        // R10: exit request while ready
        @(negedge clk);
        exit_req = 1'b1;
        @(negedge clk);
        exit_req = 1'b0;
        chk(ready && cke && cmd == CMD_NOP, "R10 exit ignored", {ready, cke}, 3);
        @(negedge clk);
        chk(ready && cke, "R10 still ready", {ready, cke}, 3);

        // R9: entry with busy banks
        banks_idle = 1'b0; enter_req = 1'b1;
        @(negedge clk);
        enter_req = 1'b0; banks_idle = 1'b1;
        chk(err && ready && cke && cmd == CMD_NOP, "R9 busy entry ignored",
            {err, ready, cke}, 7);
        repeat (3) @(negedge clk);
        chk(err && ready, "R9 error sticky", {err, ready}, 3);
        run_seq(0, 1, 2);
        chk(err == 1'b1, "R9 sticky across sequence", err, 1);
        rst_n = 1'b0;
        @(negedge clk);
        chk(err == 1'b0 && !ready, "R9 cleared by reset", {err, ready}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ready == 1'b1, "R8 ready after second reset", ready, 1);

        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: got %0d expected %0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule